// File: doc/BRIEF.md
# Integer Add-Subtract-Compare Unit

This unit is the arithmetic slice of a 64-bit integer execute stage. It takes two operands and a 7-bit function code. Operand A always comes from a register. Operand B is either a register value or an immediate that was already widened before it reaches the unit. The unit returns a 64-bit result, an overflow-trap flag and an illegal-operation flag.

The supported operations fall into four groups:
- Addition and subtraction at 32-bit or 64-bit width.
- Scaled forms that first multiply A by 4 or 8.
- Comparisons that yield 0 or 1.
- A lane-wise unsigned byte compare that yields an 8-bit mask.

Each 32-bit operation works on the low halves of A and B. Its result is sign-extended from bit 31 to fill all 64 bits.

The arithmetic is combinational. It is followed by an optional output register, selected by the parameter `REG_OUT`. With the default value of 1, a code presented before a rising edge appears on the outputs after that edge. Delivering the trap, reading the register file and extracting the immediate are all left to the surrounding pipeline.

Top module: `iarith_unit`

## Requirements
- R1: Codes 0x00 and 0x40 add the low 32 bits of A and B. The 32-bit sum is sign-extended from bit 31 to 64 bits, and the upper halves of the inputs are ignored.
- R2: Codes 0x20 and 0x60 return the 64-bit sum A+B, modulo 2^64.
- R3: Scaled adds first shift A left by 2 or by 3, then add B. Codes 0x02 (by 4) and 0x12 (by 8) give a sign-extended 32-bit result. Codes 0x22 (by 4) and 0x32 (by 8) give a 64-bit result.
- R4: The subtract codes return A-B: 0x09 and 0x49 at 32 bits (sign-extended), 0x29 and 0x69 at 64 bits. The scaled subtracts are 0x0b and 0x1b (A times 4 or 8, at 32 bits) and 0x2b and 0x3b (A times 4 or 8, at 64 bits).
- R5: An add overflows when the sign bits of A and B are equal and the sign bit of the result differs from the sign bit of A. The sign bit is bit 31 for code 0x40 and bit 63 for code 0x60.
- R6: A subtract overflows when the sign bits of A and B differ and the sign bit of the result differs from the sign bit of A. The sign bit is bit 31 for code 0x49 and bit 63 for code 0x69.
- R7: The overflow flag can be set only by codes 0x40, 0x60, 0x49 and 0x69. When an overflow occurs, the wrapped result is still returned.
- R8: The compare codes return 1 when the relation holds and 0 when it does not. They are: 0x2d A equals B; 0x6d A is at most B (signed); 0x4d A is less than B (signed); 0x3d A is at most B (unsigned); 0x1d A is less than B (unsigned).
- R9: Code 0x0f sets result bit i when byte i of A (bits 8i+7 down to 8i) is at least byte i of B, compared as unsigned values. Result bits 63 down to 8 are zero.
- R10: Any code not listed above sets the illegal-operation flag and forces the result to zero and the overflow flag to 0.
- R11: With REG_OUT=1, the outputs change only at a rising clock edge and reflect the inputs sampled at that edge. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B (register value or widened immediate) |
| func | input | 7 | Function code |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Overflow on a trapping code |
| illegal_op | output | 1 | Function code not recognised |

## Verification
The arithmetic codes are driven with operands that cross the 32-bit sign boundary. One set places junk in the upper halves, which shows whether the narrow forms truly ignore those bits and sign-extend from bit 31. Another set shifts a set bit out of the top of A, which separates a scale by 4 from a scale by 8. Each overflow pair runs once through the non-trapping code and once through the trapping code. This shows that the flag depends on the code and that the wrapped result is written in both cases.

The compare codes use equal operands and operands with mixed signs. Equal operands distinguish "less than" from "at most". Mixed signs distinguish signed from unsigned ordering. The byte compare uses lanes with equal bytes and lanes with 0x80 against 0x7f, which would order the other way if the comparison were signed.

// File: rtl/iarith_pkg.sv
// Package: function-code values and the decoded control word shared by the
// unit's submodules. Assumes a 7-bit function code.
package iarith_pkg;

    localparam int FUNC_W = 7;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_CMP   = 2'd1,
        CLS_BYTE  = 2'd2,
        CLS_NONE  = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_SLE = 3'd1,
        REL_SLT = 3'd2,
        REL_ULE = 3'd3,
        REL_ULT = 3'd4
    } rel_e;

    typedef struct packed {
        op_class_e  cls;
        logic       is_sub;
        logic       narrow;
        logic [1:0] shamt;
        logic       trap;
        rel_e       rel;
    } ctrl_t;

endpackage

// File: rtl/iarith_decode.sv
// Decoder: turns the 7-bit function code into a control word. An unknown
// code yields class CLS_NONE. Purely combinational.
module iarith_decode
    import iarith_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output ctrl_t             ctrl
);

    // Map each recognised code onto its operation class and modifiers.
    always_comb begin
        ctrl = '{cls: CLS_NONE, is_sub: 1'b0, narrow: 1'b0, shamt: 2'd0,
                 trap: 1'b0, rel: REL_EQ};
        case (func)
            7'h00: begin ctrl.cls = CLS_ARITH; ctrl.narrow = 1'b1; end
            7'h40: begin ctrl.cls = CLS_ARITH; ctrl.narrow = 1'b1; ctrl.trap = 1'b1; end
            7'h02: begin ctrl.cls = CLS_ARITH; ctrl.narrow = 1'b1; ctrl.shamt = 2'd2; end
            7'h12: begin ctrl.cls = CLS_ARITH; ctrl.narrow = 1'b1; ctrl.shamt = 2'd3; end
            7'h20: begin ctrl.cls = CLS_ARITH; end
            7'h60: begin ctrl.cls = CLS_ARITH; ctrl.trap = 1'b1; end
            7'h22: begin ctrl.cls = CLS_ARITH; ctrl.shamt = 2'd2; end
            7'h32: begin ctrl.cls = CLS_ARITH; ctrl.shamt = 2'd3; end
            7'h09: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.narrow = 1'b1; end
            7'h49: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.narrow = 1'b1; ctrl.trap = 1'b1; end
            7'h0b: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.narrow = 1'b1; ctrl.shamt = 2'd2; end
            7'h1b: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.narrow = 1'b1; ctrl.shamt = 2'd3; end
            7'h29: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; end
            7'h69: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.trap = 1'b1; end
            7'h2b: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.shamt = 2'd2; end
            7'h3b: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.shamt = 2'd3; end
            7'h2d: begin ctrl.cls = CLS_CMP; ctrl.rel = REL_EQ;  end
            7'h6d: begin ctrl.cls = CLS_CMP; ctrl.rel = REL_SLE; end
            7'h4d: begin ctrl.cls = CLS_CMP; ctrl.rel = REL_SLT; end
            7'h3d: begin ctrl.cls = CLS_CMP; ctrl.rel = REL_ULE; end
            7'h1d: begin ctrl.cls = CLS_CMP; ctrl.rel = REL_ULT; end
            7'h0f: begin ctrl.cls = CLS_BYTE; end
            default: ;
        endcase
    end

endmodule

// File: rtl/iarith_addsub.sv
// Adder/subtractor: forms (A << shamt) +/- B with a single carry chain.
// In narrow mode the result is sign-extended from the half-width sign bit.
// Overflow is judged on the unscaled A, which is correct because only
// unscaled codes trap. Combinational.
module iarith_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    input  logic              narrow,
    input  logic [1:0]        shamt,
    input  logic              trap,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_scaled;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] raw;
    logic              sa, sb, sr;

    // Scale A, invert B for subtraction and sum with carry-in.
    always_comb begin
        a_scaled = a << shamt;
        b_eff    = is_sub ? ~b : b;
        raw      = a_scaled + b_eff + {{(DATA_W-1){1'b0}}, is_sub};
    end

    // Select the width of the result and sign-extend the narrow form.
    always_comb begin
        if (narrow)
            sum = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        else
            sum = raw;
    end

    // Pick sign bits at the active width and apply the overflow rules.
    always_comb begin
        sa = narrow ? a[HALF_W-1]   : a[DATA_W-1];
        sb = narrow ? b[HALF_W-1]   : b[DATA_W-1];
        sr = narrow ? raw[HALF_W-1] : raw[DATA_W-1];
        if (is_sub)
            ovf = trap & (sa != sb) & (sr != sa);
        else
            ovf = trap & (sa == sb) & (sr != sa);
    end

endmodule

// File: rtl/iarith_cmp.sv
// Comparator: full-width equality and signed/unsigned ordering returned as
// 0 or 1, plus a per-byte unsigned greater-or-equal mask. Combinational.
module iarith_cmp
    import iarith_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  rel_e              rel,
    output logic [DATA_W-1:0] rel_res,
    output logic [DATA_W-1:0] lane_res
);

    localparam int LANES = DATA_W / 8;

    logic             hit;
    logic [LANES-1:0] lane_ge;

    // Evaluate the selected relation at full width.
    always_comb begin
        case (rel)
            REL_EQ:  hit = (a == b);
            REL_SLE: hit = ($signed(a) <= $signed(b));
            REL_SLT: hit = ($signed(a) <  $signed(b));
            REL_ULE: hit = (a <= b);
            REL_ULT: hit = (a <  b);
            default: hit = 1'b0;
        endcase
        rel_res = {{(DATA_W-1){1'b0}}, hit};
    end

    // One unsigned comparator per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ge[g] = (a[8*g +: 8] >= b[8*g +: 8]);
    end

    // Place the lane mask in the low bits and zero the rest.
    always_comb begin
        lane_res = {{(DATA_W-LANES){1'b0}}, lane_ge};
    end

endmodule

// File: rtl/iarith_unit.sv
// Integer add/subtract/compare unit: decodes the function code, runs the
// adder and the comparator side by side and selects the result. An optional
// output register (REG_OUT=1) adds one cycle of latency and has a synchronous
// active-low reset. Assumes B already holds the widened immediate when one
// is used.
module iarith_unit
    import iarith_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [FUNC_W-1:0] func,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap,
    output logic              illegal_op
);

    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = DATA_W / 8;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] sum, rel_res, lane_res;
    logic              sum_ovf;
    logic [DATA_W-1:0] res_d;
    logic              ovf_d, ill_d;

    iarith_decode u_dec (
        .func (func),
        .ctrl (ctrl)
    );

    iarith_addsub #(.DATA_W(DATA_W)) u_add (
        .a      (op_a),
        .b      (op_b),
        .is_sub (ctrl.is_sub),
        .narrow (ctrl.narrow),
        .shamt  (ctrl.shamt),
        .trap   (ctrl.trap),
        .sum    (sum),
        .ovf    (sum_ovf)
    );

    iarith_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a        (op_a),
        .b        (op_b),
        .rel      (ctrl.rel),
        .rel_res  (rel_res),
        .lane_res (lane_res)
    );

    // Select the result by class; an unknown code gives zero and flags it.
    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        ill_d = 1'b0;
        case (ctrl.cls)
            CLS_ARITH: begin res_d = sum; ovf_d = sum_ovf; end
            CLS_CMP:   res_d = rel_res;
            CLS_BYTE:  res_d = lane_res;
            default:   ill_d = 1'b1;
        endcase
    end

    if (REG_OUT) begin : g_reg
        // Capture the outputs; a synchronous reset clears them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result     <= '0;
                ovf_trap   <= 1'b0;
                illegal_op <= 1'b0;
            end else begin
                result     <= res_d;
                ovf_trap   <= ovf_d;
                illegal_op <= ill_d;
            end
        end

        AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            illegal_op |-> (result == '0 && !ovf_trap)); // R10
        AST_TRAP_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_trap |-> ($past(func) == 7'h40 || $past(func) == 7'h60 ||
                          $past(func) == 7'h49 || $past(func) == 7'h69)); // R7
        AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(func) == 7'h2d || $past(func) == 7'h6d ||
             $past(func) == 7'h4d || $past(func) == 7'h3d || $past(func) == 7'h1d))
            |-> (result[DATA_W-1:1] == '0)); // R8
        AST_LANE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func) == 7'h0f) |-> (result[DATA_W-1:LANES] == '0)); // R9
        AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(func) == 7'h00 || $past(func) == 7'h09 ||
             $past(func) == 7'h12 || $past(func) == 7'h1b))
            |-> (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})); // R1
    end else begin : g_comb
        // Drive the outputs straight from the selection logic.
        always_comb begin
            result     = res_d;
            ovf_trap   = ovf_d;
            illegal_op = ill_d;
        end
    end

endmodule

// File: tb/test_iarith_unit.sv
// Directed bench for iarith_unit: each task drives one scenario and checks it.
module test_iarith_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [6:0]  func = '0;
    logic [63:0] result;
    logic        ovf_trap, illegal_op;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    iarith_unit i_iarith_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a       (op_a),
        .op_b       (op_b),
        .func       (func),
        .result     (result),
        .ovf_trap   (ovf_trap),
        .illegal_op (illegal_op)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cmp(input string tag, input logic [63:0] r, input logic o,
                       input logic il);
        checks = checks + 1;
        if (result !== r || ovf_trap !== o || illegal_op !== il) begin
            failures = failures + 1;
            $display("FAIL %s: got res=%h ovf=%b ill=%b exp res=%h ovf=%b ill=%b",
                     tag, result, ovf_trap, illegal_op, r, o, il);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic run(input string tag, input logic [6:0] f, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] r, input logic o,
                       input logic il);
        @(negedge clk);
        func = f; op_a = a; op_b = b;
        @(negedge clk);
        cmp(tag, r, o, il);
    endtask

    task automatic t_reset();
        cmp("R11 reset state", 64'h0, 1'b0, 1'b0);
    endtask

    task automatic t_add();
        run("R1 add32 wraps to negative", 7'h00, 64'h7fffffff, 64'h1, 64'hffffffff_80000000, 1'b0, 1'b0);
        run("R1 add32 ignores upper halves", 7'h00, 64'h12345678_00000005, 64'hffff0000_00000003, 64'h8, 1'b0, 1'b0);
        run("R2 add64 carry out dropped", 7'h20, 64'hffffffff_ffffffff, 64'h2, 64'h1, 1'b0, 1'b0);
        run("R2 add64 no-trap code no flag", 7'h20, 64'h7fffffff_ffffffff, 64'h1, 64'h80000000_00000000, 1'b0, 1'b0);
    endtask

    task automatic t_scaled();
        run("R3 scale4 add32", 7'h02, 64'h3, 64'h5, 64'h11, 1'b0, 1'b0);
        run("R3 scale8 add32 sign-extends", 7'h12, 64'h10000000, 64'h0, 64'hffffffff_80000000, 1'b0, 1'b0);
        run("R3 scale4 add64 drops top bit", 7'h22, 64'h40000000_00000000, 64'h1, 64'h1, 1'b0, 1'b0);
        run("R3 scale8 add64", 7'h32, 64'h5, 64'h7, 64'd47, 1'b0, 1'b0);
    endtask

    task automatic t_sub();
        run("R4 sub32 negative", 7'h09, 64'h1, 64'h2, 64'hffffffff_ffffffff, 1'b0, 1'b0);
        run("R4 scale4 sub32", 7'h0b, 64'd10, 64'd1, 64'd39, 1'b0, 1'b0);
        run("R4 scale8 sub32", 7'h1b, 64'd1, 64'd9, 64'hffffffff_ffffffff, 1'b0, 1'b0);
        run("R4 sub64", 7'h29, 64'h0, 64'h1, 64'hffffffff_ffffffff, 1'b0, 1'b0);
        run("R4 scale4 sub64", 7'h2b, 64'd2, 64'd3, 64'd5, 1'b0, 1'b0);
        run("R4 scale8 sub64", 7'h3b, 64'd2, 64'd20, 64'hffffffff_fffffffc, 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        run("R5 add32 trap overflow", 7'h40, 64'h7fffffff, 64'h1, 64'hffffffff_80000000, 1'b1, 1'b0);
        run("R5 add64 trap overflow", 7'h60, 64'h7fffffff_ffffffff, 64'h1, 64'h80000000_00000000, 1'b1, 1'b0);
        run("R5 add64 trap negatives no ovf", 7'h60, 64'hffffffff_ffffffff, 64'hffffffff_ffffffff, 64'hffffffff_fffffffe, 1'b0, 1'b0);
        run("R6 sub32 trap overflow", 7'h49, 64'h80000000, 64'h1, 64'h7fffffff, 1'b1, 1'b0);
        run("R6 sub64 trap overflow", 7'h69, 64'h80000000_00000000, 64'h1, 64'h7fffffff_ffffffff, 1'b1, 1'b0);
        run("R6 sub64 trap same signs no ovf", 7'h69, 64'd5, 64'd3, 64'd2, 1'b0, 1'b0);
        run("R7 sub32 no-trap same operands no flag", 7'h09, 64'h80000000, 64'h1, 64'h7fffffff, 1'b0, 1'b0);
    endtask

    task automatic t_compare();
        run("R8 eq true", 7'h2d, 64'h55, 64'h55, 64'h1, 1'b0, 1'b0);
        run("R8 eq false", 7'h2d, 64'h1, 64'h2, 64'h0, 1'b0, 1'b0);
        run("R8 sle negative", 7'h6d, 64'hffffffff_ffffffff, 64'h0, 64'h1, 1'b0, 1'b0);
        run("R8 sle equal", 7'h6d, 64'h9, 64'h9, 64'h1, 1'b0, 1'b0);
        run("R8 slt equal", 7'h4d, 64'h9, 64'h9, 64'h0, 1'b0, 1'b0);
        run("R8 slt mixed sign", 7'h4d, 64'hffffffff_fffffffb, 64'h3, 64'h1, 1'b0, 1'b0);
        run("R8 ule unsigned big", 7'h3d, 64'hffffffff_ffffffff, 64'h0, 64'h0, 1'b0, 1'b0);
        run("R8 ult unsigned", 7'h1d, 64'h0, 64'hffffffff_ffffffff, 64'h1, 1'b0, 1'b0);
        run("R8 ult equal", 7'h1d, 64'h7, 64'h7, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic t_bytes();
        run("R9 lane mask mixed", 7'h0f, 64'h00ff7f80_01020304, 64'h01007f7f_02020304, 64'h77, 1'b0, 1'b0);
        run("R9 lane mask all equal", 7'h0f, 64'h0, 64'h0, 64'hff, 1'b0, 1'b0);
    endtask

    task automatic t_illegal();
        run("R10 unknown 0x7f", 7'h7f, 64'h7fffffff_ffffffff, 64'h1, 64'h0, 1'b0, 1'b1);
        run("R10 unknown 0x01", 7'h01, 64'h5, 64'h6, 64'h0, 1'b0, 1'b1);
    endtask

    // Outputs must hold until the next rising edge after an input change.
    task automatic t_latency();
        @(negedge clk);
        func = 7'h20; op_a = 64'h10; op_b = 64'h20;
        #1;
        cmp("R11 output held before edge", 64'h0, 1'b0, 1'b1);
        @(negedge clk);
        cmp("R11 output after edge", 64'h30, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        cmp("R11 synchronous reset clears", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_scaled();
        t_sub();
        t_overflow();
        t_compare();
        t_bytes();
        t_illegal();
        t_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule